// File: doc/BRIEF.md
# Per-Pin Input Filter with Glitch and Debounce Modes

This block cleans up a vector of general-purpose input pins before software reads them or change-detection logic uses them. Every pin first passes through a multi-stage synchronizer. Each pin then runs in one of three modes, chosen at run time: unfiltered, where the synchronized level goes straight out; a glitch filter that runs on the system clock; or a debouncer that samples on a slow tick derived from a separate slow clock.

Software writes to set/clear register pairs, so it can change the mode bits of some pins without a read-modify-write. One divider value, shared by all pins, sets the debounce tick period. The divider counts in the slow-clock domain. Its output toggle is synchronized into the system domain and turned into a single-cycle tick.

Top module: `pin_input_filter`

## Requirements
- R1: After reset, all three readable registers (filter status 0x08, slow-select status 0x18, divider 0x1C) read zero, so every pin is unfiltered and in glitch mode, and the divider is 0.
- R2: A write to 0x00 sets the filter-enable bit of each pin whose `wr_data` bit is 1. A write to 0x04 clears those bits. Bits whose data bit is 0 keep their value. Offset 0x08 reads the enable bits in bit positions equal to the pin index.
- R3: A write to 0x14 puts each pin whose data bit is 1 into debounce mode. A write to 0x10 returns those pins to glitch mode. Offset 0x18 reads the selection, where 1 means debounce and 0 means glitch.
- R4: A write to 0x1C loads `wr_data[13:0]` into the divider. A read of 0x1C returns that value in bits 13:0, with zeros above.
- R5: When a pin's filter is disabled, `pin_out` equals `pin_raw` delayed by SYNC_STAGES system clocks. With the default of two stages, a level driven just after a clock edge appears after the second following edge.
- R6: In glitch mode, the output takes a new level only after the synchronized input has held that level on two consecutive system-clock samples. A change reaches the output four clock edges after `pin_raw` changes, and a one-clock pulse never reaches the output.
- R7: In debounce mode, the sampling tick comes once every 2*(DIV+1) slow-clock cycles. The output takes a new level only after two consecutive ticks have seen it, so a pulse shorter than one tick period never passes. A lasting change passes between P+2 and 2P+4 system clocks after the input changes, where P is the tick period in system clocks.
- R8: Each pin's mode applies to that pin only. Pins in different modes, driven by the same input pulse, each respond according to their own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| slow_clk | input | 1 | Slow clock that drives the debounce divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data, combinational from `rd_addr` |
| pin_raw | input | NUM_PINS | Raw pin levels |
| pin_out | output | NUM_PINS | Filtered pin levels |

## Verification
The bench sweeps the pulse width in glitch mode from one clock upward. A filter that accepts a single matching sample would let the one-clock pulse through, and one that needs three samples would block the two-clock pulse. It also measures the exact latency. In debounce mode, the bench steps the divider through several values and drives both a pulse one clock shorter than the tick period and a lasting change. A divider that ignores DIV, or that ticks on every slow edge, shows up as a latency outside the window computed from 2*(DIV+1). A mixed-mode pass sends one pulse to pins in all three modes, which exposes a decode that applies one pin's mode to its neighbours.

// File: rtl/pif_pkg.sv
package pif_pkg;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned OFS_W   = 8;

   localparam logic [OFS_W-1:0] OFS_FLT_SET   = 8'h00;
   localparam logic [OFS_W-1:0] OFS_FLT_CLR   = 8'h04;
   localparam logic [OFS_W-1:0] OFS_FLT_STAT  = 8'h08;
   localparam logic [OFS_W-1:0] OFS_GLITCH    = 8'h10;
   localparam logic [OFS_W-1:0] OFS_DEBOUNCE  = 8'h14;
   localparam logic [OFS_W-1:0] OFS_MODE_STAT = 8'h18;
   localparam logic [OFS_W-1:0] OFS_DIVIDER   = 8'h1C;
endpackage

// File: rtl/pif_regs.sv
module pif_regs
   import pif_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned DIV_W    = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [OFS_W-1:0]    wr_addr,
   input  logic [BUS_W-1:0]    wr_data,
   input  logic [OFS_W-1:0]    rd_addr,
   output logic [BUS_W-1:0]    rd_data,
   output logic [NUM_PINS-1:0] filt_en,
   output logic [NUM_PINS-1:0] slow_sel,
   output logic [DIV_W-1:0]    div_val
);
   logic [NUM_PINS-1:0] wr_mask;
   assign wr_mask = wr_data[NUM_PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_en  <= '0;
         slow_sel <= '0;
         div_val  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            OFS_FLT_SET:  filt_en  <= filt_en | wr_mask;
            OFS_FLT_CLR:  filt_en  <= filt_en & ~wr_mask;
            OFS_DEBOUNCE: slow_sel <= slow_sel | wr_mask;
            OFS_GLITCH:   slow_sel <= slow_sel & ~wr_mask;
            OFS_DIVIDER:  div_val  <= wr_data[DIV_W-1:0];
            default:      ;
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         OFS_FLT_STAT:  rd_data[NUM_PINS-1:0] = filt_en;
         OFS_MODE_STAT: rd_data[NUM_PINS-1:0] = slow_sel;
         OFS_DIVIDER:   rd_data[DIV_W-1:0]    = div_val;
         default:       rd_data = '0;
      endcase
   end

   AST_FLT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_FLT_SET) |=>
      ((filt_en & $past(wr_mask)) == $past(wr_mask))); // R2
   AST_FLT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_FLT_CLR) |=>
      ((filt_en & $past(wr_mask)) == '0)); // R2
   AST_GLITCH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_GLITCH) |=>
      ((slow_sel & $past(wr_mask)) == '0)); // R3
   AST_DIV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == OFS_DIVIDER) |=>
      (div_val == $past(wr_data[DIV_W-1:0]))); // R4
endmodule

// File: rtl/pif_slow_div.sv
module pif_slow_div #(
   parameter int unsigned DIV_W     = 14,
   parameter int unsigned TICK_SYNC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_clk,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);
   logic [DIV_W-1:0]     cnt_q;
   logic                 tog_q;
   logic [TICK_SYNC-1:0] tsync_q;
   logic                 prev_q;

   // Slow domain: the toggle flips after DIV+1 slow cycles, so a full
   // toggle period is 2*(DIV+1) slow cycles. The divider value is
   // treated as quasi-static when it crosses into this domain.
   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tog_q <= 1'b0;
      end else if (cnt_q >= div_val) begin
         cnt_q <= '0;
         tog_q <= ~tog_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // System domain: synchronize the toggle, emit one tick per rising edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tsync_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         tsync_q <= {tsync_q[TICK_SYNC-2:0], tog_q};
         prev_q  <= tsync_q[TICK_SYNC-1];
      end
   end

   assign tick = tsync_q[TICK_SYNC-1] & ~prev_q;

   AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R7
endmodule

// File: rtl/pif_pin_filter.sv
module pif_pin_filter (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic filt_en,
   input  logic slow_sel,
   input  logic tick,
   output logic filt_out
);
   logic level_q;
   logic pend_q;
   logic slow_q;
   logic step;

   assign step = slow_sel ? tick : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         pend_q  <= 1'b0;
         slow_q  <= 1'b0;
      end else begin
         slow_q <= slow_sel;
         if (!filt_en) begin
            level_q <= sync_in;
            pend_q  <= 1'b0;
         end else if (slow_sel != slow_q) begin
            pend_q  <= 1'b0;
         end else if (step) begin
            if (sync_in != level_q) begin
               if (pend_q) begin
                  level_q <= sync_in;
                  pend_q  <= 1'b0;
               end else begin
                  pend_q  <= 1'b1;
               end
            end else begin
               pend_q <= 1'b0;
            end
         end
      end
   end

   assign filt_out = filt_en ? level_q : sync_in;

   AST_BYPASS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!filt_en) |-> (level_q == $past(sync_in))); // R5
   AST_CHANGE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(filt_en) && level_q != $past(level_q)) |-> $past(pend_q)); // R6
   AST_DEBOUNCE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(filt_en && slow_sel) && level_q != $past(level_q)) |-> $past(tick)); // R7
endmodule

// File: rtl/pin_input_filter.sv
module pin_input_filter
   import pif_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned DIV_W       = 14,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TICK_SYNC   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                slow_clk,
   input  logic                wr_en,
   input  logic [7:0]          wr_addr,
   input  logic [31:0]         wr_data,
   input  logic [7:0]          rd_addr,
   output logic [31:0]         rd_data,
   input  logic [NUM_PINS-1:0] pin_raw,
   output logic [NUM_PINS-1:0] pin_out
);
   localparam int unsigned SYNC_W = SYNC_STAGES * NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > BUS_W) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..32");
   end
   if (DIV_W < 1 || DIV_W > BUS_W) begin : g_bad_div
      $error("DIV_W must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TICK_SYNC < 2) begin : g_bad_tick
      $error("TICK_SYNC must be at least 2");
   end

   logic [NUM_PINS-1:0] filt_en;
   logic [NUM_PINS-1:0] slow_sel;
   logic [DIV_W-1:0]    div_val;
   logic                tick;
   logic [SYNC_STAGES-1:0][NUM_PINS-1:0] sync_q;
   logic [NUM_PINS-1:0] pin_sync;

   pif_regs #(.NUM_PINS(NUM_PINS), .DIV_W(DIV_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .filt_en  (filt_en),
      .slow_sel (slow_sel),
      .div_val  (div_val)
   );

   pif_slow_div #(.DIV_W(DIV_W), .TICK_SYNC(TICK_SYNC)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .slow_clk (slow_clk),
      .div_val  (div_val),
      .tick     (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= SYNC_W'({sync_q[SYNC_STAGES-2:0], pin_raw});
   end

   assign pin_sync = sync_q[SYNC_STAGES-1];

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      pif_pin_filter u_flt (
         .clk      (clk),
         .rst_n    (rst_n),
         .sync_in  (pin_sync[p]),
         .filt_en  (filt_en[p]),
         .slow_sel (slow_sel[p]),
         .tick     (tick),
         .filt_out (pin_out[p])
      );
   end
endmodule

// File: tb/pin_input_filter_bench.sv
module pin_input_filter_bench;
   logic        clk = 1'b0;
   logic        slow_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [31:0] pin_raw = '0;
   logic [31:0] pin_out;

   int n_chk = 0;
   int n_fail = 0;

   pin_input_filter u_pin_input_filter (
      .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .pin_raw(pin_raw), .pin_out(pin_out)
   );

   always #4 clk = ~clk;                       // 125 MHz
   initial begin
      #2;
      forever #16 slow_clk = ~slow_clk;        // 4 system clocks per slow cycle
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_range(input string req, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic measure(input logic [31:0] target, input int limit, output int lat);
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (pin_out !== target && lat < limit);
   endtask

   // Drive a pulse of width w clocks, return OR of outputs over a window.
   task automatic pulse(input logic [31:0] m, input int w, input int win, output logic [31:0] seen);
      seen = '0;
      @(negedge clk);
      pin_raw = m;
      for (int i = 0; i < w; i++) begin
         @(negedge clk);
         seen |= pin_out;
      end
      pin_raw = '0;
      for (int i = 0; i < win; i++) begin
         @(negedge clk);
         seen |= pin_out;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] seen;
      logic [31:0] hist [24];
      int lat;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(8'h08, d); chk("R1 filter status", d, 32'h0);
      rd(8'h18, d); chk("R1 mode status", d, 32'h0);
      rd(8'h1C, d); chk("R1 divider", d, 32'h0);
      chk("R1 output", pin_out, 32'h0);

      // R2: filter set/clear
      wr(8'h00, 32'h0000_00F0); rd(8'h08, d); chk("R2 set", d, 32'h0000_00F0);
      wr(8'h00, 32'h0000_0F00); rd(8'h08, d); chk("R2 set keeps", d, 32'h0000_0FF0);
      wr(8'h04, 32'h0000_0030); rd(8'h08, d); chk("R2 clear", d, 32'h0000_0FC0);
      wr(8'h04, 32'hFFFF_FFFF); rd(8'h08, d); chk("R2 clear all", d, 32'h0);

      // R3: mode select
      wr(8'h14, 32'h8000_0001); rd(8'h18, d); chk("R3 debounce set", d, 32'h8000_0001);
      wr(8'h14, 32'h0001_0000); rd(8'h18, d); chk("R3 debounce keeps", d, 32'h8001_0001);
      wr(8'h10, 32'h8000_0000); rd(8'h18, d); chk("R3 glitch clears", d, 32'h0001_0001);
      wr(8'h10, 32'hFFFF_FFFF); rd(8'h18, d); chk("R3 all glitch", d, 32'h0);

      // R4: divider width
      wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d); chk("R4 divider mask", d, 32'h0000_3FFF);
      wr(8'h1C, 32'h0000_1235); rd(8'h1C, d); chk("R4 divider value", d, 32'h0000_1235);
      wr(8'h1C, 32'h0);

      // R5: bypass, two-stage latency
      for (int i = 0; i < 24; i++) hist[i] = (i * 32'h9E37_79B9) ^ (i << 5);
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         if (i >= 2) chk("R5 bypass delay", pin_out, hist[i-2]);
         pin_raw = hist[i];
      end
      @(negedge clk); pin_raw = '0;
      repeat (4) @(negedge clk);
      chk("R5 bypass settle", pin_out, 32'h0);

      // R6: glitch filter width sweep
      wr(8'h00, 32'hFFFF_FFFF);
      repeat (4) @(negedge clk);
      for (int w = 1; w <= 4; w++) begin
         pulse(32'hA5C3_0F69, w, 10, seen);
         chk("R6 glitch width", seen, (w >= 2) ? 32'hA5C3_0F69 : 32'h0);
         chk("R6 glitch returns", pin_out, 32'h0);
      end
      @(negedge clk); pin_raw = 32'hFFFF_FFFF;
      measure(32'hFFFF_FFFF, 20, lat);
      chk_range("R6 glitch rise latency", lat, 4, 4);
      pin_raw = 32'h0;
      measure(32'h0, 20, lat);
      chk_range("R6 glitch fall latency", lat, 4, 4);

      // R7: debounce sweep over divider values
      wr(8'h14, 32'hFFFF_FFFF);
      for (int dv = 0; dv < 4; dv++) begin
         int per;
         per = 8 * (dv + 1);
         wr(8'h1C, dv);
         repeat (3 * per + 4) @(negedge clk);
         pulse(32'hFFFF_FFFF, per - 1, 3 * per, seen);
         chk("R7 short pulse blocked", seen, 32'h0);
         @(negedge clk); pin_raw = 32'hFFFF_FFFF;
         measure(32'hFFFF_FFFF, 4 * per + 10, lat);
         chk_range("R7 debounce rise latency", lat, per + 2, 2 * per + 4);
         pin_raw = 32'h0;
         measure(32'h0, 4 * per + 10, lat);
         chk_range("R7 debounce fall latency", lat, per + 2, 2 * per + 4);
      end

      // R8: mixed modes on one pulse
      wr(8'h1C, 32'h0);
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h00, 32'h5555_5555);
      repeat (30) @(negedge clk);
      pulse(32'hFFFF_FFFF, 1, 10, seen);
      chk("R8 glitch vs bypass", seen, 32'hAAAA_AAAA);
      wr(8'h14, 32'h0000_FFFF);
      repeat (30) @(negedge clk);
      pulse(32'hFFFF_FFFF, 3, 12, seen);
      chk("R8 three modes", seen, 32'hFFFF_AAAA);
      repeat (30) @(negedge clk);
      chk("R8 settle", pin_out, 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule